// File: doc/BRIEF.md
# Dual 16-bit Vector Shifter

This block shifts a 32-bit word as two separate 16-bit lanes. Both lanes move by the same signed distance. The distance comes from the low five bits of a 16-bit amount input, read as a two's-complement number. A positive distance shifts left and a negative distance shifts right. The lanes never exchange bits.

Two mode inputs select the behaviour:

- In arithmetic mode, right shifts copy the sign bit into the vacated positions. Left shifts either truncate to 16 bits or, when saturation is enabled, clamp a lane that overflows to the largest value of its own sign.
- In logical mode, both directions fill with zeros and the saturation input is ignored.

The block also produces five status flags from the packed result:

- zero: set when either lane is zero.
- negative: set when either lane has its top bit set.
- carry and two overflow flags: these always read clear for this operation.

The datapath is combinational and feeds a single output register. A result and its flags appear one clock after the operands are presented with `in_vld`. The output holds its value while `in_vld` is low.

Top module: `dvs_shift16x2`

## Requirements
- R1: Active-low reset clears `result`, all flags and `out_vld`. After reset, `out_vld` equals the previous cycle's `in_vld`. `result` and flags load one cycle after a cycle with `in_vld` high and hold unchanged otherwise.
- R2: The distance is `shift_amt[4:0]` as a two's-complement value from -16 to +15. Bits 15..5 of `shift_amt` have no effect.
- R3: A left shift without saturation (arithmetic with `sat_en` low, or logical mode) shifts each lane and keeps its low 16 bits, for example 0x8001 by 15 gives 0x8000.
- R4: An arithmetic left shift with `sat_en` high clamps a lane whose exact signed product does not fit in 16 bits to 0x7FFF if the lane was non-negative, and to 0x8000 if it was negative. A lane that fits is shifted normally.
- R5: An arithmetic right shift (`arith_mode`=1) sign-extends each lane. A distance of -16 yields 0xFFFF or 0x0000 per lane. `sat_en` has no effect on right shifts.
- R6: A logical right shift (`arith_mode`=0) zero-fills each lane. A distance of -16 yields 0x0000. `sat_en` has no effect in logical mode.
- R7: A distance of zero passes both lanes through unchanged, and flags are still derived from that result.
- R8: `flag_zero` is 1 when result bits 31..16 or bits 15..0 are all zero.
- R9: `flag_neg` is 1 when result bit 31 or bit 15 is set.
- R10: `flag_carry`, `flag_ovf0` and `flag_ovf1` are 0 for every operation, including saturated ones.
- R11: No bit moves between the lanes: the high lane (bits 31..16) depends only on input bits 31..16, and the low lane only on bits 15..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operands valid this cycle |
| src_data | input | 32 | Packed operand: high lane 31..16, low lane 15..0 |
| shift_amt | input | 16 | Shift distance; only bits 4..0 are used |
| arith_mode | input | 1 | 1 = arithmetic, 0 = logical |
| sat_en | input | 1 | Saturate arithmetic left shifts |
| out_vld | output | 1 | Result registered from a valid input |
| result | output | 32 | Packed shifted result |
| flag_zero | output | 1 | Either lane zero |
| flag_neg | output | 1 | Either lane negative |
| flag_carry | output | 1 | Carry flag, always clear |
| flag_ovf0 | output | 1 | First overflow flag, always clear |
| flag_ovf1 | output | 1 | Second overflow flag, always clear |

## Verification
The assertions check the following on every cycle:

- the valid pipeline timing and the hold of `result` while idle;
- the zero-distance pass-through;
- the sign preservation of saturating left shifts and of arithmetic right shifts in each lane;
- the zero top bit of logical right shifts;
- the permanently clear carry and overflow flags.

The exact clamp values, the truncated bit patterns, the -16 boundary, the ignored upper amount bits and the lane isolation can only be shown by the bench's scenarios. These compare every result against a model computed from exact signed products.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

    typedef struct packed {
        logic zero;
        logic neg;
        logic carry;
        logic ovf0;
        logic ovf1;
    } dvs_flags_t;

    localparam dvs_flags_t DVS_FLAGS_CLR = '{zero: 1'b0, neg: 1'b0, carry: 1'b0, ovf0: 1'b0, ovf1: 1'b0};

endpackage

// File: rtl/dvs_amt_decode.sv
// Turns the signed distance field into a direction and an unsigned magnitude.
module dvs_amt_decode #(
    parameter int AMT_W = 5
) (
    input  logic [AMT_W-1:0] amt_field,
    output logic             dir_right,
    output logic [AMT_W-1:0] mag
);
    always_comb begin
        dir_right = amt_field[AMT_W-1];
        // the most negative value negates to itself, read unsigned it is 2**(AMT_W-1)
        mag = dir_right ? (~amt_field + 1'b1) : amt_field;
    end
endmodule

// File: rtl/dvs_lane_shifter.sv
// One lane: left with optional clamp, arithmetic or logical right.
module dvs_lane_shifter #(
    parameter int LANE_W = 16,
    parameter int MAG_W  = 5
) (
    input  logic [LANE_W-1:0] lane_in,
    input  logic              dir_right,
    input  logic [MAG_W-1:0]  mag,
    input  logic              arith,
    input  logic              sat,
    output logic [LANE_W-1:0] lane_out
);
    localparam int EXT_W = 2 * LANE_W;
    localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic [EXT_W-1:0]   wide_l;
    logic [LANE_W:0]    spill;
    logic               lane_ovf;
    logic [LANE_W-1:0]  asr_v;
    logic [LANE_W-1:0]  lsr_v;

    always_comb begin
        wide_l   = {{LANE_W{lane_in[LANE_W-1]}}, lane_in} << mag;
        spill    = wide_l[EXT_W-1:LANE_W-1];
        lane_ovf = !((&spill) || !(|spill));
        asr_v    = $unsigned($signed(lane_in) >>> mag);
        lsr_v    = lane_in >> mag;
    end

    always_comb begin
        if (dir_right) begin
            lane_out = arith ? asr_v : lsr_v;
        end else if (arith && sat && lane_ovf) begin
            lane_out = lane_in[LANE_W-1] ? NEG_MIN : POS_MAX;
        end else begin
            lane_out = wide_l[LANE_W-1:0];
        end
    end
endmodule

// File: rtl/dvs_flag_gen.sv
// ORs per-lane zero and sign conditions into packed status flags.
module dvs_flag_gen
    import dvs_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int LANES  = 2
) (
    input  logic [LANES*LANE_W-1:0] res,
    output dvs_flags_t              flags
);
    logic [LANES-1:0] lane_zero;
    logic [LANES-1:0] lane_neg;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_zero[g] = (res[g*LANE_W +: LANE_W] == '0);
        assign lane_neg[g]  = res[g*LANE_W + LANE_W - 1];
    end

    always_comb begin
        flags       = DVS_FLAGS_CLR;
        flags.zero  = |lane_zero;
        flags.neg   = |lane_neg;
    end
endmodule

// File: rtl/dvs_shift16x2.sv
module dvs_shift16x2
    import dvs_pkg::*;
#(
    parameter int LANE_W   = 16,
    parameter int LANES    = 2,
    parameter int AMT_IN_W = 16,
    parameter int AMT_W    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic [LANES*LANE_W-1:0] src_data,
    input  logic [AMT_IN_W-1:0]     shift_amt,
    input  logic                    arith_mode,
    input  logic                    sat_en,
    output logic                    out_vld,
    output logic [LANES*LANE_W-1:0] result,
    output logic                    flag_zero,
    output logic                    flag_neg,
    output logic                    flag_carry,
    output logic                    flag_ovf0,
    output logic                    flag_ovf1
);
    localparam int DATA_W = LANES * LANE_W;

    logic              dir_right;
    logic [AMT_W-1:0]  mag;
    logic [DATA_W-1:0] res_d;
    dvs_flags_t        flags_d;
    dvs_flags_t        flags_q;
    logic              unused_amt_hi;

    assign unused_amt_hi = ^shift_amt[AMT_IN_W-1:AMT_W];

    dvs_amt_decode #(.AMT_W(AMT_W)) u_dec (
        .amt_field (shift_amt[AMT_W-1:0]),
        .dir_right (dir_right),
        .mag       (mag)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dvs_lane_shifter #(.LANE_W(LANE_W), .MAG_W(AMT_W)) u_lane (
            .lane_in   (src_data[g*LANE_W +: LANE_W]),
            .dir_right (dir_right),
            .mag       (mag),
            .arith     (arith_mode),
            .sat       (sat_en),
            .lane_out  (res_d[g*LANE_W +: LANE_W])
        );
    end

    dvs_flag_gen #(.LANE_W(LANE_W), .LANES(LANES)) u_flags (
        .res   (res_d),
        .flags (flags_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            result  <= '0;
            flags_q <= DVS_FLAGS_CLR;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                result  <= res_d;
                flags_q <= flags_d;
            end
        end
    end

    always_comb begin
        flag_zero  = flags_q.zero;
        flag_neg   = flags_q.neg;
        flag_carry = flags_q.carry;
        flag_ovf0  = flags_q.ovf0;
        flag_ovf1  = flags_q.ovf1;
    end
endmodule

// File: rtl/dvs_shift16x2_chk.sv
module dvs_shift16x2_chk #(
    parameter int LANE_W   = 16,
    parameter int LANES    = 2,
    parameter int AMT_IN_W = 16,
    parameter int AMT_W    = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_vld,
    input logic [LANES*LANE_W-1:0] src_data,
    input logic [AMT_IN_W-1:0]     shift_amt,
    input logic                    arith_mode,
    input logic                    sat_en,
    input logic                    out_vld,
    input logic [LANES*LANE_W-1:0] result,
    input logic                    flag_carry,
    input logic                    flag_ovf0,
    input logic                    flag_ovf1
);
    p_vld_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(result)));

    p_zero_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && shift_amt[AMT_W-1:0] == '0) |=> (result == $past(src_data)));

    p_flags_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (!flag_carry && !flag_ovf0 && !flag_ovf1));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int TOP = g*LANE_W + LANE_W - 1;

        p_sat_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && arith_mode && sat_en && !shift_amt[AMT_W-1])
            |=> (result[TOP] == $past(src_data[TOP])));

        p_asr_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && arith_mode && shift_amt[AMT_W-1])
            |=> (result[TOP] == $past(src_data[TOP])));

        p_lsr_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_vld && !arith_mode && shift_amt[AMT_W-1])
            |=> !result[TOP]);
    end
endmodule

bind dvs_shift16x2 dvs_shift16x2_chk #(
    .LANE_W(LANE_W), .LANES(LANES), .AMT_IN_W(AMT_IN_W), .AMT_W(AMT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_vld     (in_vld),
    .src_data   (src_data),
    .shift_amt  (shift_amt),
    .arith_mode (arith_mode),
    .sat_en     (sat_en),
    .out_vld    (out_vld),
    .result     (result),
    .flag_carry (flag_carry),
    .flag_ovf0  (flag_ovf0),
    .flag_ovf1  (flag_ovf1)
);

// File: tb/tb_dvs_shift16x2.sv
`timescale 1ns/1ps
module tb_dvs_shift16x2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [31:0] src_data;
    logic [15:0] shift_amt;
    logic        arith_mode;
    logic        sat_en;
    logic        out_vld;
    logic [31:0] result;
    logic        flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1;

    always #2.5 clk = ~clk;

    dvs_shift16x2 dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .src_data(src_data),
        .shift_amt(shift_amt), .arith_mode(arith_mode), .sat_en(sat_en),
        .out_vld(out_vld), .result(result), .flag_zero(flag_zero),
        .flag_neg(flag_neg), .flag_carry(flag_carry), .flag_ovf0(flag_ovf0),
        .flag_ovf1(flag_ovf1)
    );

    typedef struct {
        logic [31:0] res;
        logic        z;
        logic        n;
        string       tag;
    } exp_t;

    exp_t        sbq[$];
    int          n_chk  = 0;
    int          n_fail = 0;
    logic [31:0] last_res;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, expv);
        end
    endtask

    // model from exact signed products, independent of bit tricks
    function automatic logic [15:0] mdl_lane(input logic [15:0] x, input int amt,
                                             input bit ar, input bit sat);
        longint full;
        if (amt >= 0) begin
            full = longint'($signed(x)) * (longint'(1) << amt);
            if (ar && sat && full > 32767)  return 16'h7FFF;
            if (ar && sat && full < -32768) return 16'h8000;
            return full[15:0];
        end else begin
            if (ar) begin
                full = longint'($signed(x));
                for (int k = 0; k < -amt; k++) full = (full < 0) ? (full - 1) / 2 : full / 2;
                return full[15:0];
            end
            return 16'(32'(x) >> (-amt));
        end
    endfunction

    task automatic send(input logic [31:0] d, input logic [15:0] a,
                        input bit ar, input bit sat, input string tag);
        exp_t e;
        int   amt;
        @(negedge clk);
        src_data   = d;
        shift_amt  = a;
        arith_mode = ar;
        sat_en     = sat;
        in_vld     = 1'b1;
        amt        = int'($signed(a[4:0]));
        e.res[31:16] = mdl_lane(d[31:16], amt, ar, sat);
        e.res[15:0]  = mdl_lane(d[15:0],  amt, ar, sat);
        e.z   = (e.res[31:16] == 16'h0) || (e.res[15:0] == 16'h0);
        e.n   = e.res[31] || e.res[15];
        e.tag = tag;
        sbq.push_back(e);
        last_res = e.res;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_vld === 1'b1) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R1", "unexpected out_vld", {31'b0, out_vld}, 32'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(result === e.res, e.tag, "result", result, e.res);
                check(flag_zero === e.z, "R8", "flag_zero", {31'b0, flag_zero}, {31'b0, e.z});
                check(flag_neg === e.n, "R9", "flag_neg", {31'b0, flag_neg}, {31'b0, e.n});
                check({flag_carry, flag_ovf0, flag_ovf1} === 3'b000, "R10", "carry/ovf",
                      {29'b0, flag_carry, flag_ovf0, flag_ovf1}, 32'h0);
            end
        end
    end

    function automatic string tag_for(input logic [15:0] a, input bit ar, input bit sat);
        if (a[4:0] == 5'd0) return "R7";
        if (!a[4]) return (ar && sat) ? "R4" : "R3";
        return ar ? "R5" : "R6";
    endfunction

    initial begin
        rst_n = 1'b0; in_vld = 1'b1; src_data = 32'hDEAD_BEEF;
        shift_amt = 16'h0003; arith_mode = 1'b1; sat_en = 1'b0;
        repeat (3) @(negedge clk);
        check(result === 32'h0 && out_vld === 1'b0, "R1", "reset result", result, 32'h0);
        check({flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1} === 5'b0, "R1",
              "reset flags", {27'b0, flag_zero, flag_neg, flag_carry, flag_ovf0, flag_ovf1}, 32'h0);
        in_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // truncating and saturating left shifts
        send(32'h0100_8001, 16'd15, 1, 0, "R3");
        send(32'h0100_8001, 16'd15, 1, 1, "R4");
        send(32'h0100_8001, 16'd1,  1, 0, "R3");
        send(32'h0100_8001, 16'd1,  1, 1, "R4");
        send(32'h0000_FFF0, 16'd15, 1, 1, "R4");
        send(32'h3FFF_C000, 16'd1,  1, 1, "R4");
        send(32'h4000_BFFF, 16'd1,  1, 1, "R4");
        send(32'h0100_8001, 16'd15, 0, 1, "R3");
        // right shifts, including the -16 boundary
        send(32'h0100_8000, 16'hFFF1, 1, 0, "R5");
        send(32'h0100_8000, 16'hFFF1, 1, 1, "R5");
        send(32'h7FFF_8000, 16'h0010, 1, 0, "R5");
        send(32'h0100_8000, 16'hFFF1, 0, 0, "R6");
        send(32'hFFFF_8000, 16'h0010, 0, 0, "R6");
        send(32'hF0F0_8421, 16'hFFFC, 0, 1, "R6");
        // upper amount bits ignored
        send(32'h1234_8765, 16'hFFE1, 1, 0, "R2");
        send(32'h1234_8765, 16'h0030, 1, 0, "R2");
        send(32'h1234_8765, 16'hABC0, 0, 1, "R2");
        // zero distance
        send(32'h8000_0000, 16'h0000, 1, 1, "R7");
        send(32'h7FFF_FFFF, 16'h0000, 0, 0, "R7");
        // lane isolation
        send(32'h0001_8000, 16'h001F, 0, 0, "R11");
        send(32'h0001_8000, 16'd1,    0, 0, "R11");
        send(32'h8000_0001, 16'h001F, 1, 0, "R11");
        send(32'hFFFF_0000, 16'd4,    1, 0, "R11");
        // varied stream
        for (int i = 0; i < 80; i++) begin
            logic [31:0] d;
            logic [15:0] a;
            bit ar, sat;
            d   = $urandom;
            a   = 16'($urandom);
            ar  = bit'($urandom % 2);
            sat = bit'($urandom % 2);
            send(d, a, ar, sat, tag_for(a, ar, sat));
        end
        @(negedge clk);
        in_vld = 1'b0;
        src_data = 32'h5555_AAAA;
        repeat (3) begin
            @(negedge clk);
            check(result === last_res && out_vld === 1'b0, "R1", "idle hold", result, last_res);
        end
        check(sbq.size() == 0, "R1", "scoreboard drained", sbq.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule